// File: doc/BRIEF.md
# Card Socket Interrupt Event Controller

This block watches the status pins of a removable-card socket, plus a one-cycle completion pulse from the socket power sequencer, and turns them into sticky status-change flags and a pass-through functional interrupt. The same shared pins mean different things depending on the kind of card in the socket. A memory card reports changes on its battery-detect and ready pins. An I/O or bus-mastering card uses the first battery-detect pin as a status-change line and the ready pin as an interrupt request.

Each status-change flag has its own enable bit. A small four-register interface reads the flags and writes the enables, the routing and the clear mode. Status-change and functional interrupts are routed separately to a parameterised set of interrupt outputs. Flags are cleared in one of two ways, chosen by a configuration bit: by writing ones to them, or by reading the flag register.

Top module: `sock_evt_ctrl`

## Requirements
- R1: After reset, every register reads zero and every interrupt output is low.
- R2: With `card_kind` = 0 (memory card), any transition on `pin_bvd1`, `pin_bvd2` or `pin_rdy` sets flag bit 0, bit 1 or bit 2 respectively.
- R3: With a nonzero `card_kind` (1 I/O, 2 or 3 bus-mastering), a rising edge on `pin_bvd1` sets flag bit 3. A falling edge on `pin_bvd1` sets no flag. No change on `pin_bvd2` or `pin_rdy` sets any flag.
- R4: For every card kind, any transition on `pin_cd1_n` or `pin_cd2_n` sets flag bit 4.
- R5: A high `pwr_done` at a clock edge sets flag bit 5 at that same edge.
- R6: A flag is set whether or not it is enabled. Register address 1, bits 5:0, enable flag bits 5:0. A status-change interrupt is raised while any flag is both set and enabled. It appears on the output numbered by the route field at address 2, bits SEL_W-1:0.
- R7: The functional interrupt is a level with no enable bit. It is high when the card kind is nonzero, the synchronised `pin_rdy` is high, and both synchronised card-detect pins are low (card present). It drives the output numbered by address 2, bits 4+SEL_W-1:4. Flag register bit 6 reads it back.
- R8: While address 3 bit 0 is 0 (write-one-clear mode), a write to address 0 clears exactly the flag bits written as 1 and leaves the others unchanged.
- R9: While address 3 bit 0 is 1 (read-clear mode), a read of address 0 returns the current flags and clears them all at that edge. An event arriving in the same cycle as the read stays set. Writes to address 0 are ignored.
- R10: Address 1 reads back bits 5:0 and address 2 reads back bits SEL_W-1:0 and 4+SEL_W-1:4, as last written. Address 3 reads back bit 0 as last written. All other bits read zero.
- R11: Every card pin passes through a SYNC_STAGES-flop synchroniser (default two). A pin change applied before clock edge E0 becomes visible in the flags only after edge E0+SYNC_STAGES, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_kind | input | 2 | 0 memory, 1 I/O, 2/3 bus-mastering |
| pin_bvd1 | input | 1 | Battery detect 1 / status-change line |
| pin_bvd2 | input | 1 | Battery detect 2 |
| pin_rdy | input | 1 | Ready / interrupt request |
| pin_cd1_n | input | 1 | Card detect 1, low when seated |
| pin_cd2_n | input | 1 | Card detect 2, low when seated |
| pwr_done | input | 1 | Power-up sequence complete pulse (synchronous) |
| reg_addr | input | 2 | Register address: 0 flags, 1 enable, 2 route, 3 config |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq_out | output | NUM_OUT | Routed system interrupt outputs |

## Verification
The hardest case to reach from the ports is a read-clear access that lands in the same cycle as a new event. A pin edge cannot be placed precisely in that window because of the synchroniser, so the bench raises `pwr_done` together with the read strobe. It then expects the read to return the old flags and flag bit 5 to survive. The synchroniser latency is exercised by sampling the flag register between edges after one pin change. Random phases toggle single pins under each card kind, interleaved with random enable, route and clear writes, and compare flags and outputs against a bench model.

// File: rtl/sock_evt_pkg.sv
`timescale 1ns/1ps
package sock_evt_pkg;
   localparam int REG_W = 8;
   localparam int NPIN  = 5;
   localparam int NFLAG = 6;

   // pin vector positions
   localparam int PIN_BVD1 = 0;
   localparam int PIN_BVD2 = 1;
   localparam int PIN_RDY  = 2;
   localparam int PIN_CD1  = 3;
   localparam int PIN_CD2  = 4;

   // flag bit positions
   localparam int FL_BATT1 = 0;
   localparam int FL_BATT2 = 1;
   localparam int FL_READY = 2;
   localparam int FL_STCHG = 3;
   localparam int FL_DETCT = 4;
   localparam int FL_PWRUP = 5;

   localparam logic [1:0] ADDR_FLAG  = 2'd0;
   localparam logic [1:0] ADDR_EN    = 2'd1;
   localparam logic [1:0] ADDR_ROUTE = 2'd2;
   localparam logic [1:0] ADDR_CFG   = 2'd3;

   localparam int ROUTE_FN_LSB = 4;

   typedef enum logic [1:0] {
      KIND_MEM = 2'd0,
      KIND_IO  = 2'd1,
      KIND_BUS = 2'd2,
      KIND_BUS2 = 2'd3
   } card_kind_e;
endpackage

// File: rtl/sock_evt_sync.sv
`timescale 1ns/1ps
module sock_evt_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] cur,
   output logic [W-1:0] prev,
   output logic         sync_ok,
   output logic         edge_ok
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sock_evt_sync: STAGES must be at least 2");
   end

   logic [W-1:0]      stg [STAGES];
   logic [STAGES:0]   vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= din;
   end

   for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[k] <= '0;
         else        stg[k] <= stg[k-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev <= '0;
         vld  <= '0;
      end else begin
         prev <= stg[STAGES-1];
         vld  <= {vld[STAGES-1:0], 1'b1};
      end
   end

   assign cur     = stg[STAGES-1];
   assign sync_ok = vld[STAGES-1];
   assign edge_ok = vld[STAGES];
endmodule

// File: rtl/sock_evt_detect.sv
`timescale 1ns/1ps
module sock_evt_detect
   import sock_evt_pkg::*;
(
   input  card_kind_e        kind,
   input  logic [NPIN-1:0]   cur,
   input  logic [NPIN-1:0]   prev,
   input  logic              sync_ok,
   input  logic              edge_ok,
   input  logic              pwr_done,
   output logic [NFLAG-1:0]  evt,
   output logic              func_lvl
);
   logic [NPIN-1:0] chg, rise;
   logic            is_mem;

   always_comb begin
      chg    = (cur ^ prev) & {NPIN{edge_ok}};
      rise   = cur & ~prev & {NPIN{edge_ok}};
      is_mem = (kind == KIND_MEM);

      evt            = '0;
      evt[FL_BATT1]  = is_mem & chg[PIN_BVD1];
      evt[FL_BATT2]  = is_mem & chg[PIN_BVD2];
      evt[FL_READY]  = is_mem & chg[PIN_RDY];
      evt[FL_STCHG]  = ~is_mem & rise[PIN_BVD1];
      evt[FL_DETCT]  = chg[PIN_CD1] | chg[PIN_CD2];
      evt[FL_PWRUP]  = pwr_done;

      func_lvl = sync_ok & ~is_mem & cur[PIN_RDY] & ~cur[PIN_CD1] & ~cur[PIN_CD2];
   end
endmodule

// File: rtl/sock_evt_regs.sv
`timescale 1ns/1ps
module sock_evt_regs
   import sock_evt_pkg::*;
#(
   parameter int SEL_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        addr,
   input  logic              wr,
   input  logic              rd,
   input  logic [REG_W-1:0]  wdata,
   input  logic [NFLAG-1:0]  evt,
   input  logic              func_lvl,
   output logic [REG_W-1:0]  rdata,
   output logic [NFLAG-1:0]  flags,
   output logic [NFLAG-1:0]  enable,
   output logic [SEL_W-1:0]  csc_sel,
   output logic [SEL_W-1:0]  func_sel,
   output logic              rc_mode
);
   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("sock_evt_regs: SEL_W must be 1..4");
   end

   logic [NFLAG-1:0] clr;

   always_comb begin
      clr = '0;
      if (addr == ADDR_FLAG) begin
         if (rc_mode && rd)       clr = '1;
         else if (!rc_mode && wr) clr = wdata[NFLAG-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags    <= '0;
         enable   <= '0;
         csc_sel  <= '0;
         func_sel <= '0;
         rc_mode  <= 1'b0;
      end else begin
         flags <= (flags & ~clr) | evt;
         if (wr) begin
            case (addr)
               ADDR_EN:    enable <= wdata[NFLAG-1:0];
               ADDR_ROUTE: begin
                  csc_sel  <= wdata[SEL_W-1:0];
                  func_sel <= wdata[ROUTE_FN_LSB +: SEL_W];
               end
               ADDR_CFG:   rc_mode <= wdata[0];
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         ADDR_FLAG: rdata[NFLAG:0] = {func_lvl, flags};
         ADDR_EN:   rdata[NFLAG-1:0] = enable;
         ADDR_ROUTE: begin
            rdata[SEL_W-1:0]              = csc_sel;
            rdata[ROUTE_FN_LSB +: SEL_W]  = func_sel;
         end
         default:   rdata[0] = rc_mode;
      endcase
   end
endmodule

// File: rtl/sock_evt_route.sv
`timescale 1ns/1ps
module sock_evt_route #(
   parameter int NUM_OUT = 2,
   parameter int SEL_W   = 1
) (
   input  logic               csc_any,
   input  logic               func_lvl,
   input  logic [SEL_W-1:0]   csc_sel,
   input  logic [SEL_W-1:0]   func_sel,
   output logic [NUM_OUT-1:0] irq
);
   for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
      assign irq[i] = (csc_any  && (csc_sel  == SEL_W'(i))) ||
                      (func_lvl && (func_sel == SEL_W'(i)));
   end
endmodule

// File: rtl/sock_evt_ctrl.sv
`timescale 1ns/1ps
module sock_evt_ctrl
   import sock_evt_pkg::*;
#(
   parameter int NUM_OUT     = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         card_kind,
   input  logic               pin_bvd1,
   input  logic               pin_bvd2,
   input  logic               pin_rdy,
   input  logic               pin_cd1_n,
   input  logic               pin_cd2_n,
   input  logic               pwr_done,
   input  logic [1:0]         reg_addr,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [7:0]         reg_wdata,
   output logic [7:0]         reg_rdata,
   output logic [NUM_OUT-1:0] irq_out
);
   localparam int SEL_W = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1;

   if (NUM_OUT < 2 || NUM_OUT > 16 || NUM_OUT != (1 << SEL_W)) begin : g_bad_out
      $error("sock_evt_ctrl: NUM_OUT must be a power of two in 2..16");
   end

   logic [NPIN-1:0]  pins_raw, cur, prev;
   logic             sync_ok, edge_ok;
   logic [NFLAG-1:0] evt, flags, enable;
   logic             func_lvl, rc_mode, csc_any;
   logic [SEL_W-1:0] csc_sel, func_sel;

   always_comb begin
      pins_raw           = '0;
      pins_raw[PIN_BVD1] = pin_bvd1;
      pins_raw[PIN_BVD2] = pin_bvd2;
      pins_raw[PIN_RDY]  = pin_rdy;
      pins_raw[PIN_CD1]  = pin_cd1_n;
      pins_raw[PIN_CD2]  = pin_cd2_n;
   end

   sock_evt_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(pins_raw),
      .cur(cur), .prev(prev), .sync_ok(sync_ok), .edge_ok(edge_ok)
   );

   sock_evt_detect u_det (
      .kind(card_kind_e'(card_kind)), .cur(cur), .prev(prev),
      .sync_ok(sync_ok), .edge_ok(edge_ok), .pwr_done(pwr_done),
      .evt(evt), .func_lvl(func_lvl)
   );

   sock_evt_regs #(.SEL_W(SEL_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
      .wdata(reg_wdata), .evt(evt), .func_lvl(func_lvl), .rdata(reg_rdata),
      .flags(flags), .enable(enable), .csc_sel(csc_sel), .func_sel(func_sel),
      .rc_mode(rc_mode)
   );

   assign csc_any = |(flags & enable);

   sock_evt_route #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W)) u_route (
      .csc_any(csc_any), .func_lvl(func_lvl), .csc_sel(csc_sel),
      .func_sel(func_sel), .irq(irq_out)
   );
endmodule

// File: rtl/sock_evt_chk.sv
`timescale 1ns/1ps
module sock_evt_chk #(
   parameter int NUM_OUT = 2,
   parameter int SEL_W   = 1,
   parameter int NFL     = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               pwr_done,
   input logic [1:0]         reg_addr,
   input logic               reg_rd,
   input logic               reg_wr,
   input logic               pin_cd1_n,
   input logic [NUM_OUT-1:0] irq_out,
   input logic [NFL-1:0]     flags,
   input logic [NFL-1:0]     enable,
   input logic [NFL-1:0]     evt,
   input logic [SEL_W-1:0]   csc_sel,
   input logic               func_lvl,
   input logic               rc_mode,
   input logic               sync_ok
);
   // R5: power-up completion pulse leaves its flag set
   p_pwr_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_done |=> flags[5]);

   // R9: a read-clear access with no new event empties the flags
   p_rc_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rc_mode && reg_rd && reg_addr == 2'd0 && evt == '0) |=> (flags == '0));

   // R6: flags never drop except through a clear access
   p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!(reg_addr == 2'd0 && ((rc_mode && reg_rd) || (!rc_mode && reg_wr))))
      |=> ((flags & $past(flags)) == $past(flags)));

   // R6: a set and enabled flag raises the selected output
   p_csc_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|(flags & enable)) |-> irq_out[csc_sel]);

   // R6/R7: nothing pending means all outputs are quiet
   p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (((flags & enable) == '0) && !func_lvl) |-> (irq_out == '0));

   // R7: no functional interrupt while card detect shows no card
   p_nocard_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_ok && $past(pin_cd1_n, 2)) |-> !func_lvl);
endmodule

bind sock_evt_ctrl sock_evt_chk #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W), .NFL(sock_evt_pkg::NFLAG)) u_chk (
   .clk(clk), .rst_n(rst_n), .pwr_done(pwr_done), .reg_addr(reg_addr),
   .reg_rd(reg_rd), .reg_wr(reg_wr), .pin_cd1_n(pin_cd1_n), .irq_out(irq_out),
   .flags(flags), .enable(enable), .evt(evt), .csc_sel(csc_sel),
   .func_lvl(func_lvl), .rc_mode(rc_mode), .sync_ok(sync_ok)
);

// File: tb/sock_evt_ctrl_test.sv
`timescale 1ns/1ps
module sock_evt_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] card_kind = 2'd0;
   logic [4:0] pins = 5'b11000;   // {cd2_n, cd1_n, rdy, bvd2, bvd1}
   logic       pwr_done = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic [1:0] irq_out;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   sock_evt_ctrl #(.NUM_OUT(2), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .card_kind(card_kind),
      .pin_bvd1(pins[0]), .pin_bvd2(pins[1]), .pin_rdy(pins[2]),
      .pin_cd1_n(pins[3]), .pin_cd2_n(pins[4]), .pwr_done(pwr_done),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
   );

   // bench model state
   logic [5:0] m_flags = 0, m_en = 0;
   logic       m_csel = 0, m_fsel = 0;

   function automatic logic [5:0] evt_of(input logic [1:0] kind, input int idx, input logic nv);
      logic [5:0] e = 0;
      case (idx)
         0: if (kind == 0) e[0] = 1; else if (nv) e[3] = 1;
         1: if (kind == 0) e[1] = 1;
         2: if (kind == 0) e[2] = 1;
         default: e[4] = 1;
      endcase
      return e;
   endfunction

   function automatic logic m_func(input logic [1:0] kind, input logic [4:0] p);
      return (kind != 0) && p[2] && !p[3] && !p[4];
   endfunction

   function automatic logic [1:0] m_irq(input logic [1:0] kind, input logic [4:0] p);
      logic [1:0] r = 0;
      if (|(m_flags & m_en)) r[m_csel] = 1'b1;
      if (m_func(kind, p))   r[m_fsel] = 1'b1;
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk); @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(posedge clk); @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic peek(input logic [1:0] a, output logic [7:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic pulse_pwr();
      pwr_done = 1'b1;
      @(posedge clk); @(negedge clk);
      pwr_done = 1'b0;
   endtask

   task automatic toggle(input int idx);
      pins[idx] = ~pins[idx];
      idle(4);
   endtask

   task automatic chk_flags(input string req, input logic [7:0] exp);
      logic [7:0] d;
      peek(2'd0, d);
      chk(d === exp, req, d, exp);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      void'($urandom(32'd20240611));
      idle(3);
      rst_n = 1'b1;
      idle(4);

      // R1: reset state
      for (int a = 0; a < 4; a++) begin
         peek(a[1:0], d);
         chk(d === 8'h00, "R1 reg reset", d, 8'h00);
      end
      chk(irq_out === 2'b00, "R1 irq reset", {6'd0, irq_out}, 8'h00);

      // R10: register readback widths
      wr(2'd1, 8'hFF); peek(2'd1, d); chk(d === 8'h3F, "R10 enable rb", d, 8'h3F);
      wr(2'd2, 8'hFF); peek(2'd2, d); chk(d === 8'h11, "R10 route rb", d, 8'h11);
      wr(2'd3, 8'hFF); peek(2'd3, d); chk(d === 8'h01, "R10 cfg rb", d, 8'h01);
      wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd3, 8'h00);
      chk_flags("R10 flags untouched", 8'h00);

      // R11: synchroniser latency (memory card, bvd2 edge)
      pins[1] = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      chk_flags("R11 not yet after two edges", 8'h00);
      @(posedge clk); @(negedge clk);
      chk_flags("R11 set after third edge", 8'h02);

      // R5 and R8: power pulse, partial write-one-clear
      pulse_pwr();
      chk_flags("R5 power flag", 8'h22);
      wr(2'd0, 8'h02);
      chk_flags("R8 partial clear", 8'h20);

      // R6: flag set but not enabled -> quiet; enable -> routed output
      chk(irq_out === 2'b00, "R6 masked quiet", {6'd0, irq_out}, 8'h00);
      wr(2'd1, 8'h20); #1;
      chk(irq_out === 2'b01, "R6 enabled out0", {6'd0, irq_out}, 8'h01);
      wr(2'd2, 8'h01); #1;
      chk(irq_out === 2'b10, "R6 routed out1", {6'd0, irq_out}, 8'h02);
      wr(2'd0, 8'h3F); #1;
      chk(irq_out === 2'b00, "R8 clear drops irq", {6'd0, irq_out}, 8'h00);
      wr(2'd1, 8'h00); wr(2'd2, 8'h00);

      // R2: memory card transitions both ways
      toggle(0); chk_flags("R2 bvd1 rise", 8'h01);
      wr(2'd0, 8'h01);
      toggle(0); chk_flags("R2 bvd1 fall", 8'h01);
      toggle(1); chk_flags("R2 bvd2 fall", 8'h03);
      toggle(2); chk_flags("R2 rdy rise", 8'h07);
      toggle(2); wr(2'd0, 8'h3F);
      chk_flags("R8 clear all", 8'h00);

      // R3: I/O card interpretation
      card_kind = 2'd1;
      toggle(0); chk_flags("R3 status rise", 8'h08);
      wr(2'd0, 8'h08);
      toggle(0); chk_flags("R3 status fall ignored", 8'h00);
      toggle(1); chk_flags("R3 bvd2 ignored", 8'h00);
      toggle(2); chk_flags("R3 rdy no flag", 8'h00);

      // R4 and R7: insertion, functional level
      toggle(3); chk_flags("R4 cd1 edge", 8'h10);
      wr(2'd0, 8'h10);
      toggle(4); chk_flags("R7 card present func", 8'h50);
      wr(2'd2, 8'h10); #1;
      chk(irq_out === 2'b10, "R7 func out1 no mask", {6'd0, irq_out}, 8'h02);
      card_kind = 2'd0; #1;
      chk(irq_out === 2'b00, "R7 memory kind no func", {6'd0, irq_out}, 8'h00);
      card_kind = 2'd2;
      toggle(3); chk_flags("R7 removal drops func", 8'h10);
      wr(2'd0, 8'h3F); wr(2'd2, 8'h00);

      // R9: read-clear mode
      wr(2'd3, 8'h01);
      pulse_pwr();
      wr(2'd0, 8'h3F);
      chk_flags("R9 write ignored", 8'h20);
      reg_addr = 2'd0; reg_rd = 1'b1; pwr_done = 1'b1;
      #1 d = reg_rdata;
      chk(d === 8'h20, "R9 read returns flags", d, 8'h20);
      @(posedge clk); @(negedge clk);
      reg_rd = 1'b0; pwr_done = 1'b0;
      chk_flags("R9 same-cycle event kept", 8'h20);
      rd(2'd0, d);
      chk_flags("R9 read cleared", 8'h00);
      wr(2'd3, 8'h00);

      // random phases per card kind
      m_flags = 0; m_en = 0; m_csel = 0; m_fsel = 0;
      for (int ph = 0; ph < 3; ph++) begin
         card_kind = ph[1:0];
         for (int it = 0; it < 150; it++) begin
            int op;
            logic [7:0] w;
            op = $urandom % 10;
            w  = 8'($urandom);
            if (op == 0) begin
               wr(2'd1, w); m_en = w[5:0];
            end else if (op == 1) begin
               wr(2'd2, w); m_csel = w[0]; m_fsel = w[4];
            end else if (op == 2) begin
               wr(2'd0, w); m_flags = m_flags & ~w[5:0];
            end else if (op == 3) begin
               pulse_pwr(); m_flags[5] = 1'b1;
            end else begin
               int idx;
               idx = $urandom % 5;
               m_flags = m_flags | evt_of(card_kind, idx, ~pins[idx]);
               toggle(idx);
            end
            chk_flags("R2/R3/R4 random flags",
                      {1'b0, m_func(card_kind, pins), m_flags});
            chk(irq_out === m_irq(card_kind, pins), "R6/R7 random irq",
                {6'd0, irq_out}, {6'd0, m_irq(card_kind, pins)});
         end
      end

      done = 1;
      summary();
      $finish;
   end
endmodule